// File: doc/BRIEF.md
# Low-Power Entry and Wake Controller

This block sits beside a processor core and decides what happens when the core reports that it has run its sleep instruction. A configuration bit picks the depth. In light sleep only the core clock stops, and the peripherals and the external clock pin keep running. In deep standby the core and peripheral clocks both stop, and the external clock pin is driven in one of three ways set by two configuration bits. Standby entry also fires a one-cycle strobe that clears a chosen group of peripheral registers.

The controller also handles the way back. Any interrupt line, whether the non-maskable input, an external request or an on-chip peripheral request, brings the core out of light sleep. The core's interrupt-block bit has no say in this. On that wake the controller raises a one-cycle exception request and stores a code that names the winning source. A power-on or manual reset request brings the core out of either low-power state and reports that exit on a separate pulse. In this block, deep standby is left by reset only.

Top module: `lpm_ctrl`

## Requirements
- R1: In the run state (`lp_state` = 0), a `sleep_req` cycle with `standby_sel` = 0 and no reset request moves the block to light sleep (`lp_state` = 1) on that clock edge. In light sleep `core_clk_en` = 0, `periph_clk_en` = 1 and `clkout_mode` = 0 (clock running).
- R2: In the run state, a `sleep_req` cycle with `standby_sel` = 1 and no reset request moves the block to deep standby (`lp_state` = 2) on that edge. In deep standby `core_clk_en` and `periph_clk_en` are both 0.
- R3: In light sleep, any set bit among `nmi`, `irq` and `pirq` returns the block to the run state on the next edge. `exc_req` is high for exactly that one following cycle.
- R4: The level of `blk_bit` does not change whether or when an interrupt wakes the block from light sleep.
- R5: On an interrupt wake, `evt_code` takes the code of the winning source on the same edge that raises `exc_req`. `nmi` wins and gives 0x01. Next come the `irq` bits, lowest index first, with code 0x10+index. Last come the `pirq` bits, lowest index first, with code 0x40+index. At all other times `evt_code` holds its value.
- R6: In either low-power state, `por_req` or `mrst_req` returns the block to the run state on the next edge. `rst_wake` is high for exactly that one following cycle.
- R7: In deep standby, `clkout_mode` is 0 (running) when `clkout_en` = 1. When `clkout_en` = 0 it is 1 (driven low) if `clkout_hiz` = 0 and 2 (high impedance) if `clkout_hiz` = 1.
- R8: `periph_init` is high for exactly the one cycle that follows entry into deep standby. It never rises on entry into light sleep.
- R9: Interrupts have no effect in deep standby: the state stays 2, `exc_req` stays 0 and `evt_code` does not change.
- R10: A reset request takes priority over an interrupt in the same cycle. The block leaves light sleep through `rst_wake`, with `exc_req` at 0 and `evt_code` unchanged. A `sleep_req` that comes together with a reset request in the run state is dropped.
- R11: A `sleep_req` that arrives while already in light sleep or deep standby leaves the state unchanged and fires no `periph_init`.
- R12: While `rst_n` is low at a clock edge, the block goes to the run state with both clock enables at 1, `clkout_mode` = 0, `evt_code` = 0 and all pulses at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running controller clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| sleep_req | input | 1 | One-cycle pulse: the core has run its sleep instruction |
| standby_sel | input | 1 | 0 = light sleep, 1 = deep standby |
| clkout_en | input | 1 | External clock pin keeps running in standby |
| clkout_hiz | input | 1 | External clock pin goes high impedance in standby when not running |
| blk_bit | input | 1 | Core interrupt-block bit; ignored for wake-up |
| nmi | input | 1 | Non-maskable interrupt |
| irq | input | N_IRQ | External interrupt requests |
| pirq | input | N_PIRQ | On-chip peripheral interrupt requests |
| por_req | input | 1 | Power-on reset request |
| mrst_req | input | 1 | Manual reset request |
| lp_state | output | 2 | 0 run, 1 light sleep, 2 deep standby |
| core_clk_en | output | 1 | Core clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| clkout_mode | output | 2 | External clock pin: 0 running, 1 low, 2 high impedance |
| periph_init | output | 1 | One-cycle peripheral-register initialise strobe |
| exc_req | output | 1 | One-cycle interrupt exception request after a wake |
| rst_wake | output | 1 | One-cycle flag: a low-power state was left by reset |
| evt_code | output | CODE_W | Code of the interrupt source that caused the last wake |

## Verification
All results come from one register stage. A state change, the clock enables, `clkout_mode`, `periph_init`, `exc_req`, `rst_wake` and `evt_code` all show the effect of a stimulus in the first cycle after the edge that samples it. The bench drives inputs and samples outputs 1 ns after each rising edge, so each check reads the cycle right after its stimulus. It then checks again one cycle later to confirm that each pulse has dropped. The sweep runs through every mode bit, clock-out setting, block-bit level and wake source. Directed cases then cover source priority and reset-versus-interrupt collisions.

// File: rtl/lpm_pkg.sv
// Shared types for the low-power entry controller.
// Assumes: encodings below are visible at the top ports and must not change.
package lpm_pkg;
    typedef enum logic [1:0] {
        LP_RUN  = 2'd0,
        LP_NAP  = 2'd1,
        LP_DEEP = 2'd2
    } lp_state_e;

    typedef enum logic [1:0] {
        CKO_RUN = 2'd0,
        CKO_LOW = 2'd1,
        CKO_HIZ = 2'd2
    } cko_mode_e;
endpackage

// File: rtl/lpm_wake_enc.sv
// Wake-source encoder: flags any pending interrupt and picks the code of the
// highest-priority one (NMI, then IRQ lowest index, then peripheral lowest index).
// Assumes: inputs are already synchronous to clk; purely combinational.
module lpm_wake_enc #(
    parameter int          N_IRQ     = 4,
    parameter int          N_PIRQ    = 4,
    parameter int          CODE_W    = 8,
    parameter logic [7:0]  NMI_CODE  = 8'h01,
    parameter logic [7:0]  IRQ_BASE  = 8'h10,
    parameter logic [7:0]  PIRQ_BASE = 8'h40
) (
    input  logic              nmi,
    input  logic [N_IRQ-1:0]  irq,
    input  logic [N_PIRQ-1:0] pirq,
    output logic              wake_any,
    output logic [CODE_W-1:0] src_code
);
    localparam logic [CODE_W-1:0] NMI_C  = CODE_W'(NMI_CODE);
    localparam logic [CODE_W-1:0] IRQ_C  = CODE_W'(IRQ_BASE);
    localparam logic [CODE_W-1:0] PIRQ_C = CODE_W'(PIRQ_BASE);

    // Per-line code tables, one entry per request line.
    logic [CODE_W-1:0] irq_code  [N_IRQ];
    logic [CODE_W-1:0] pirq_code [N_PIRQ];

    for (genvar gi = 0; gi < N_IRQ; gi++) begin : g_irq_code
        assign irq_code[gi] = IRQ_C + CODE_W'(gi);
    end
    for (genvar gp = 0; gp < N_PIRQ; gp++) begin : g_pirq_code
        assign pirq_code[gp] = PIRQ_C + CODE_W'(gp);
    end

    // Any pending request counts as a wake event.
    assign wake_any = nmi | (|irq) | (|pirq);

    // Priority pick: later assignments override, so scan low-to-high priority.
    always_comb begin
        src_code = '0;
        for (int p = N_PIRQ - 1; p >= 0; p--) begin
            if (pirq[p]) src_code = pirq_code[p];
        end
        for (int q = N_IRQ - 1; q >= 0; q--) begin
            if (irq[q]) src_code = irq_code[q];
        end
        if (nmi) src_code = NMI_C;
    end
endmodule

// File: rtl/lpm_seq.sv
// Power-state sequencer: enters light sleep or deep standby on a sleep request,
// leaves on interrupt (light sleep only) or reset request, and issues the
// one-cycle strobes and the latched event code.
// Assumes: sleep_req is a pulse from the core; reset requests beat interrupts.
module lpm_seq
    import lpm_pkg::*;
#(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep_req,
    input  logic              standby_sel,
    input  logic              rst_any,
    input  logic              wake_any,
    input  logic [CODE_W-1:0] src_code,
    output lp_state_e         state_q,
    output logic              exc_req,
    output logic              rst_wake,
    output logic              periph_init,
    output logic [CODE_W-1:0] evt_code
);
    lp_state_e state_d;
    logic      go_sleep;
    logic      int_wake;

    // Entry is allowed only from run and only without a competing reset.
    assign go_sleep = (state_q == LP_RUN) && sleep_req && !rst_any;
    // Interrupt wake applies to light sleep only, and loses to reset.
    assign int_wake = (state_q == LP_NAP) && wake_any && !rst_any;

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LP_RUN:  if (go_sleep) state_d = standby_sel ? LP_DEEP : LP_NAP;
            LP_NAP:  if (rst_any || wake_any) state_d = LP_RUN;
            LP_DEEP: if (rst_any) state_d = LP_RUN;
            default: state_d = LP_RUN;
        endcase
    end

    // State register and one-cycle strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= LP_RUN;
            exc_req     <= 1'b0;
            rst_wake    <= 1'b0;
            periph_init <= 1'b0;
        end else begin
            state_q     <= state_d;
            exc_req     <= int_wake;
            rst_wake    <= (state_q != LP_RUN) && rst_any;
            periph_init <= go_sleep && standby_sel;
        end
    end

    // Event-code register, written only on an interrupt wake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_code <= '0;
        end else if (int_wake) begin
            evt_code <= src_code;
        end
    end

    AST_NAP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LP_RUN && sleep_req && !rst_any && !standby_sel) |=> (state_q == LP_NAP)); // R1
    AST_DEEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LP_RUN && sleep_req && !rst_any && standby_sel) |=> (state_q == LP_DEEP && periph_init)); // R2
    AST_INIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        periph_init |=> !periph_init); // R8
    AST_RST_BEATS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != LP_RUN && rst_any) |=> (state_q == LP_RUN && rst_wake && !exc_req)); // R10
    AST_REQ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LP_DEEP && !rst_any) |=> (state_q == LP_DEEP && !periph_init)); // R11
    AST_EVT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !int_wake |=> $stable(evt_code)); // R5
endmodule

// File: rtl/lpm_clk_gate.sv
// Clock-enable decode: maps the power state and the clock-pin configuration
// to the core/peripheral enables and the external clock pin mode.
// Assumes: configuration bits are static while in standby; combinational.
module lpm_clk_gate
    import lpm_pkg::*;
(
    input  lp_state_e   state_q,
    input  logic        clkout_en,
    input  logic        clkout_hiz,
    output logic        core_clk_en,
    output logic        periph_clk_en,
    output cko_mode_e   clkout_mode
);
    // Core runs only in run; peripherals stop only in deep standby.
    always_comb begin
        core_clk_en   = (state_q == LP_RUN);
        periph_clk_en = (state_q != LP_DEEP);
    end

    // Pin mode: only deep standby consults the two configuration bits.
    always_comb begin
        if (state_q != LP_DEEP || clkout_en) begin
            clkout_mode = CKO_RUN;
        end else if (clkout_hiz) begin
            clkout_mode = CKO_HIZ;
        end else begin
            clkout_mode = CKO_LOW;
        end
    end
endmodule

// File: rtl/lpm_ctrl.sv
// Low-power entry controller top: ties the wake encoder, sequencer and clock
// gating together and exposes the state and strobes.
// Assumes: all inputs synchronous to clk; rst_n is synchronous active-low.
module lpm_ctrl
    import lpm_pkg::*;
#(
    parameter int          N_IRQ     = 4,
    parameter int          N_PIRQ    = 4,
    parameter int          CODE_W    = 8,
    parameter logic [7:0]  NMI_CODE  = 8'h01,
    parameter logic [7:0]  IRQ_BASE  = 8'h10,
    parameter logic [7:0]  PIRQ_BASE = 8'h40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep_req,
    input  logic              standby_sel,
    input  logic              clkout_en,
    input  logic              clkout_hiz,
    input  logic              blk_bit,
    input  logic              nmi,
    input  logic [N_IRQ-1:0]  irq,
    input  logic [N_PIRQ-1:0] pirq,
    input  logic              por_req,
    input  logic              mrst_req,
    output logic [1:0]        lp_state,
    output logic              core_clk_en,
    output logic              periph_clk_en,
    output logic [1:0]        clkout_mode,
    output logic              periph_init,
    output logic              exc_req,
    output logic              rst_wake,
    output logic [CODE_W-1:0] evt_code
);
    lp_state_e         state_q;
    cko_mode_e         cko;
    logic              wake_any;
    logic              rst_any;
    logic [CODE_W-1:0] src_code;

    // Either reset request leaves a low-power state.
    assign rst_any = por_req | mrst_req;

    lpm_wake_enc #(
        .N_IRQ(N_IRQ), .N_PIRQ(N_PIRQ), .CODE_W(CODE_W),
        .NMI_CODE(NMI_CODE), .IRQ_BASE(IRQ_BASE), .PIRQ_BASE(PIRQ_BASE)
    ) u_wake_enc (
        .nmi(nmi), .irq(irq), .pirq(pirq),
        .wake_any(wake_any), .src_code(src_code)
    );

    lpm_seq #(.CODE_W(CODE_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .standby_sel(standby_sel),
        .rst_any(rst_any), .wake_any(wake_any), .src_code(src_code),
        .state_q(state_q), .exc_req(exc_req), .rst_wake(rst_wake),
        .periph_init(periph_init), .evt_code(evt_code)
    );

    lpm_clk_gate u_clk_gate (
        .state_q(state_q), .clkout_en(clkout_en), .clkout_hiz(clkout_hiz),
        .core_clk_en(core_clk_en), .periph_clk_en(periph_clk_en), .clkout_mode(cko)
    );

    assign lp_state    = state_q;
    assign clkout_mode = cko;

    AST_BLK_NO_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LP_NAP && blk_bit && wake_any && !rst_any) |=> (exc_req && core_clk_en)); // R4
    AST_WAKE_EXC: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LP_NAP && wake_any && !rst_any) |=> (state_q == LP_RUN && exc_req)); // R3
    AST_DEEP_DEAF: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LP_DEEP && !rst_any) |=> (!exc_req && !periph_clk_en)); // R9
    AST_EXC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |=> !exc_req); // R3
endmodule

// File: tb/test_lpm_ctrl.sv
module test_lpm_ctrl;
    localparam int NI = 4;
    localparam int NP = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep_req = 0, standby_sel = 0, clkout_en = 0, clkout_hiz = 0, blk_bit = 0;
    logic nmi = 0, por_req = 0, mrst_req = 0;
    logic [NI-1:0] irq = '0;
    logic [NP-1:0] pirq = '0;
    logic [1:0] lp_state, clkout_mode;
    logic core_clk_en, periph_clk_en, periph_init, exc_req, rst_wake;
    logic [7:0] evt_code;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int exp_evt = 0;

    always #2 clk = ~clk;

    lpm_ctrl i_lpm_ctrl (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .standby_sel(standby_sel),
        .clkout_en(clkout_en), .clkout_hiz(clkout_hiz), .blk_bit(blk_bit),
        .nmi(nmi), .irq(irq), .pirq(pirq), .por_req(por_req), .mrst_req(mrst_req),
        .lp_state(lp_state), .core_clk_en(core_clk_en), .periph_clk_en(periph_clk_en),
        .clkout_mode(clkout_mode), .periph_init(periph_init), .exc_req(exc_req),
        .rst_wake(rst_wake), .evt_code(evt_code)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic clear_srcs();
        nmi = 0; irq = '0; pirq = '0; por_req = 0; mrst_req = 0; sleep_req = 0;
    endtask

    // Source index: 0 none, 1 nmi, 2.. irq, then pirq, then por, then mrst.
    task automatic apply_src(input int s);
        if (s == 1) nmi = 1;
        else if (s >= 2 && s < 2 + NI) irq[s-2] = 1'b1;
        else if (s >= 2 + NI && s < 2 + NI + NP) pirq[s-2-NI] = 1'b1;
        else if (s == 2 + NI + NP) por_req = 1;
        else if (s == 3 + NI + NP) mrst_req = 1;
    endtask

    function automatic int src_code(input int s);
        if (s == 1) return 8'h01;
        if (s >= 2 && s < 2 + NI) return 8'h10 + (s - 2);
        return 8'h40 + (s - 2 - NI);
    endfunction

    task automatic enter(input int sel);
        sleep_req = 1; standby_sel = sel[0];
        tick();
        sleep_req = 0;
    endtask

    initial begin
        #(4 * 190000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        // R12: reset state
        chk("R12 state", lp_state, 0);
        chk("R12 core_en", core_clk_en, 1);
        chk("R12 periph_en", periph_clk_en, 1);
        chk("R12 cko", clkout_mode, 0);
        chk("R12 evt", evt_code, 0);
        chk("R12 pulses", {periph_init, exc_req, rst_wake}, 0);
        rst_n = 1;
        tick();

        for (int sel = 0; sel < 2; sel++) begin
            for (int cfg = 0; cfg < 4; cfg++) begin
                for (int blk = 0; blk < 2; blk++) begin
                    for (int s = 0; s < 4 + NI + NP; s++) begin
                        int exp_cko;
                        int lp;
                        clkout_en = cfg[0]; clkout_hiz = cfg[1]; blk_bit = blk[0];
                        exp_cko = (sel == 0 || cfg[0]) ? 0 : (cfg[1] ? 2 : 1);
                        enter(sel);
                        lp = 1 + sel;
                        chk(sel ? "R2 state" : "R1 state", lp_state, lp);
                        chk("R1 core_en", core_clk_en, 0);
                        chk(sel ? "R2 periph_en" : "R1 periph_en", periph_clk_en, 1 - sel);
                        chk(sel ? "R7 cko" : "R1 cko", clkout_mode, exp_cko);
                        chk("R8 init on entry", periph_init, sel);
                        // R11: second request while asleep is ignored
                        sleep_req = 1; standby_sel = ~standby_sel;
                        tick();
                        sleep_req = 0; standby_sel = sel[0];
                        chk("R8 init width", periph_init, 0);
                        chk("R11 state held", lp_state, lp);
                        // wake attempt
                        apply_src(s);
                        tick();
                        clear_srcs();
                        if (s >= 2 + NI + NP) begin
                            chk("R6 state", lp_state, 0);
                            chk("R6 rst_wake", rst_wake, 1);
                            chk("R6 no exc", exc_req, 0);
                        end else if (s >= 1 && sel == 0) begin
                            exp_evt = src_code(s);
                            chk("R3 state", lp_state, 0);
                            chk(blk ? "R4 exc with blk" : "R3 exc", exc_req, 1);
                            chk("R5 evt", evt_code, exp_evt);
                        end else begin
                            chk(sel ? "R9 state" : "R11 idle state", lp_state, lp);
                            chk("R9 no exc", exc_req, 0);
                            chk("R9 evt held", evt_code, exp_evt);
                        end
                        if (lp_state != 0) begin
                            por_req = 1;
                            tick();
                            por_req = 0;
                            chk("R6 por exit", lp_state, 0);
                            chk("R6 rst_wake", rst_wake, 1);
                        end
                        tick();
                        chk("R3 pulses low", {exc_req, rst_wake}, 0);
                        chk("R5 evt held", evt_code, exp_evt);
                    end
                end
            end
        end

        // R5: priority among simultaneous sources
        clkout_en = 1; clkout_hiz = 0; blk_bit = 0;
        enter(0); nmi = 1; irq = 4'b0110; pirq = 4'b0001; tick(); clear_srcs();
        exp_evt = 8'h01; chk("R5 nmi wins", evt_code, exp_evt);
        tick();
        enter(0); irq = 4'b1100; pirq = 4'b0001; tick(); clear_srcs();
        exp_evt = 8'h12; chk("R5 lowest irq", evt_code, exp_evt);
        tick();
        enter(0); pirq = 4'b1010; tick(); clear_srcs();
        exp_evt = 8'h41; chk("R5 lowest pirq", evt_code, exp_evt);
        tick();

        // R10: reset and interrupt together in light sleep
        enter(0); mrst_req = 1; nmi = 1; irq = 4'b0001; tick(); clear_srcs();
        chk("R10 state", lp_state, 0);
        chk("R10 rst_wake", rst_wake, 1);
        chk("R10 no exc", exc_req, 0);
        chk("R10 evt held", evt_code, exp_evt);
        tick();
        // R10: sleep request together with reset in run is dropped
        sleep_req = 1; standby_sel = 1; por_req = 1; tick(); clear_srcs();
        chk("R10 entry dropped", lp_state, 0);
        chk("R10 no init", periph_init, 0);
        tick();

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule